// File: doc/BRIEF.md
# Lens Actuator DAC Step Sequencer

This block produces the code for a voice-coil actuator's current DAC. When it is enabled it moves the lens in up to three phases. First it jumps straight to a start point. Next it climbs a timed staircase to a float point. Last it hands over to a final-approach phase that ends at the target point. The final approach is modelled as one direct move to the target. Software programs the three points and a packed step-control byte through a simple write port. It then raises the enable bit with the mode bit set.

The block selects each phase by comparing the present code against the start and float points. If the start point is zero, the block skips the staircase. If the start point is already at or above the float point, it also skips the staircase. A nonzero reference code sends the block straight to the final approach. Each stair lasts a programmed number of 50 µs ticks. A parameter gives the number of system clocks in one tick. Each stair adds a programmed increment, and the last stair is clamped at the float point.

Top module: `lens_dac_sequencer`

## Requirements
- R1: After reset, `dac_code` is 0, `seq_phase` is 0 (idle), `seq_done` is 0, the start point is 0 and both step fields read as zero.
- R2: A write with `wr_sel` 3'b001 loads the start point, 3'b010 loads the float point and 3'b011 loads the target point, each from `wr_data`. A write with 3'b111 loads the step-control byte from `wr_data[7:0]`: bits [4:0] give the tick count per step and bits [7:5] give the code increment per step. Writes with any other `wr_sel` have no effect.
- R3: A sequence starts only when `seq_en` and `mode_sel` are both 1, and either `ref_code` is nonzero or the float and target points are both nonzero. Otherwise `seq_phase` stays 0.
- R4: One clock after the start, `seq_phase` is 1 (direct) and `dac_code` equals the start point. If the start point is 0, `dac_code` equals the float point instead.
- R5: If the code after the direct phase is below the float point, `seq_phase` becomes 2 (step) on the next clock. The code then rises by the increment once every (tick count × CLKS_PER_TICK) clocks. The first rise comes that many clocks after the step phase is entered, and the code holds steady in between.
- R6: A step never takes the code above the float point. The step that reaches the float point moves `seq_phase` to 3 (final approach).
- R7: If the code after the direct phase is at or above the float point, the next clock moves `seq_phase` to 3 without stepping.
- R8: One clock after phase 3 is entered, `dac_code` equals the target point and `seq_done` is 1. Both hold while `seq_en` stays 1, and `seq_done` is only ever 1 in phase 3.
- R9: If `ref_code` is nonzero, the start clock moves `seq_phase` straight to 3 and leaves `dac_code` unchanged.
- R10: A tick-count field of 0 acts as 1, and an increment field of 0 acts as 1.
- R11: While a sequence is running and `seq_done` is 0, writes to the three points are ignored. Such writes are accepted when the block is idle or after `seq_done` is set.
- R12: When `seq_en` is 0, the next clock sets `seq_phase` to 0 and `seq_done` to 0, and `dac_code` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_en | input | 1 | Enable; 1 starts a sequence, 0 returns the block to idle |
| mode_sel | input | 1 | Mode bit; a sequence can run only when it is 1 |
| ref_code | input | CODE_W | Reference code; nonzero selects the final approach at once |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | CODE_W | Write data |
| dac_code | output | CODE_W | Present DAC code |
| seq_phase | output | 2 | 0 idle, 1 direct, 2 step, 3 final approach |
| seq_done | output | 1 | Target point reached |

## Verification
The assertions take for granted that the three point registers change only through the write port, and that reset is held for at least two clocks. This way no history-based property looks at values from before reset. They also assume that a point is never written in the same clock in which a sequence starts. In that clock the register is not yet locked, while the direct phase uses its old value. The stimulus changes every input only at the falling clock edge, and it programs all registers while the block is idle. The point writes made during a sequence fall strictly inside the locked window.

// File: rtl/lds_pkg.sv
// Shared types for the lens DAC step sequencer.
// Holds the phase encoding seen on the seq_phase port and the register
// select codes decoded by the write port.
package lds_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DIRECT = 2'd1,
        PH_STEP   = 2'd2,
        PH_FINAL  = 2'd3
    } phase_t;

    localparam logic [2:0] SEL_PT_A = 3'b001;
    localparam logic [2:0] SEL_PT_B = 3'b010;
    localparam logic [2:0] SEL_PT_C = 3'b011;
    localparam logic [2:0] SEL_STEP = 3'b111;

endpackage

// File: rtl/lds_regs.sv
// Register file for the sequencer: three points and the step-control byte.
// Assumes wr_data is at least TIME_W+RES_W bits wide. Point writes are
// dropped while lock is high; the step byte is always writable. Zero step
// fields are presented as 1 so the downstream logic never sees 0.
module lds_regs #(
    parameter int CODE_W = 10,
    parameter int TIME_W = 5,
    parameter int RES_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              lock,
    output logic [CODE_W-1:0] pt_a,
    output logic [CODE_W-1:0] pt_b,
    output logic [CODE_W-1:0] pt_c,
    output logic [TIME_W-1:0] step_ticks,
    output logic [RES_W-1:0]  step_incr
);
    import lds_pkg::*;

    localparam int CTL_W = TIME_W + RES_W;

    logic [CTL_W-1:0] ctl_q;
    logic [TIME_W-1:0] raw_ticks;
    logic [RES_W-1:0]  raw_incr;

    // Point registers: decode the select, honour the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_a <= '0;
            pt_b <= '0;
            pt_c <= '0;
        end else if (wr_en && !lock) begin
            if (wr_sel == SEL_PT_A) pt_a <= wr_data;
            if (wr_sel == SEL_PT_B) pt_b <= wr_data;
            if (wr_sel == SEL_PT_C) pt_c <= wr_data;
        end
    end

    // Step-control byte: low field is tick count, high field is increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en && wr_sel == SEL_STEP) begin
            ctl_q <= wr_data[CTL_W-1:0];
        end
    end

    assign raw_ticks = ctl_q[TIME_W-1:0];
    assign raw_incr  = ctl_q[CTL_W-1:TIME_W];

    // Replace invalid zero settings with the smallest legal value.
    assign step_ticks = (raw_ticks == '0) ? TIME_W'(1) : raw_ticks;
    assign step_incr  = (raw_incr == '0) ? RES_W'(1) : raw_incr;

endmodule

// File: rtl/lds_step_timer.sv
// Step period timer: a prescaler making one tick per CLKS_PER_TICK clocks,
// and a down-counter of whole ticks. load restarts both, so the period
// after a load is exactly ticks*CLKS_PER_TICK clocks. expire is high in
// the last clock of the period. Assumes ticks is never 0 when loaded.
module lds_step_timer #(
    parameter int TIME_W        = 5,
    parameter int CLKS_PER_TICK = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] ticks,
    output logic              expire
);
    localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);
    localparam logic [PRE_W-1:0]  PRE_ONE  = PRE_W'(1);
    localparam logic [TIME_W-1:0] LEFT_ONE = TIME_W'(1);

    logic [PRE_W-1:0]  pre_q;
    logic [TIME_W-1:0] left_q;
    logic              tick_end;

    assign tick_end = (pre_q == PRE_LAST);
    assign expire   = tick_end && (left_q == LEFT_ONE);

    // Prescaler and tick counter; load wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            left_q <= '0;
        end else if (load) begin
            pre_q  <= '0;
            left_q <= ticks;
        end else if (left_q != '0) begin
            if (tick_end) begin
                pre_q  <= '0;
                left_q <= left_q - LEFT_ONE;
            end else begin
                pre_q <= pre_q + PRE_ONE;
            end
        end
    end

endmodule

// File: rtl/lds_seq_fsm.sv
// Phase controller and staircase generator. Picks the phase from the
// present code against the points, adds the increment on each timer
// expiry with a clamp at the float point, and models the final approach
// as one move to the target. Assumes points are stable while busy.
module lds_seq_fsm #(
    parameter int CODE_W = 10,
    parameter int RES_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_en,
    input  logic              mode_sel,
    input  logic [CODE_W-1:0] ref_code,
    input  logic [CODE_W-1:0] pt_a,
    input  logic [CODE_W-1:0] pt_b,
    input  logic [CODE_W-1:0] pt_c,
    input  logic [RES_W-1:0]  step_incr,
    input  logic              step_expire,
    output logic [CODE_W-1:0] dac_code,
    output logic [1:0]        seq_phase,
    output logic              seq_done,
    output logic              busy,
    output logic              timer_load
);
    import lds_pkg::*;

    phase_t            ph_q;
    logic [CODE_W-1:0] dac_q;
    logic              done_q;
    logic [CODE_W:0]   sum_w;
    logic [CODE_W-1:0] next_step;
    logic              ref_zero;
    logic              start_ok;

    // Next staircase code, widened by one bit so the clamp sees overflow.
    assign sum_w     = {1'b0, dac_q} + {{(CODE_W + 1 - RES_W){1'b0}}, step_incr};
    assign next_step = (sum_w >= {1'b0, pt_b}) ? pt_b : sum_w[CODE_W-1:0];

    assign ref_zero = (ref_code == '0);
    assign start_ok = seq_en && mode_sel &&
                      (!ref_zero || (pt_b != '0 && pt_c != '0));

    assign timer_load = (ph_q == PH_DIRECT) || (ph_q == PH_STEP && step_expire);
    assign busy       = (ph_q != PH_IDLE) && !done_q;

    // Phase, code and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            dac_q  <= '0;
            done_q <= 1'b0;
        end else if (!seq_en) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start_ok) begin
                        if (!ref_zero) begin
                            ph_q <= PH_FINAL;
                        end else begin
                            ph_q  <= PH_DIRECT;
                            dac_q <= (pt_a != '0) ? pt_a : pt_b;
                        end
                    end
                end
                PH_DIRECT: begin
                    ph_q <= (dac_q < pt_b) ? PH_STEP : PH_FINAL;
                end
                PH_STEP: begin
                    if (step_expire) begin
                        dac_q <= next_step;
                        if (next_step == pt_b) ph_q <= PH_FINAL;
                    end
                end
                PH_FINAL: begin
                    if (!done_q) begin
                        dac_q  <= pt_c;
                        done_q <= 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign dac_code  = dac_q;
    assign seq_phase = ph_q;
    assign seq_done  = done_q;

endmodule

// File: rtl/lens_dac_sequencer.sv
// Top of the lens DAC step sequencer. Connects the register file, the
// step timer and the phase controller. CLKS_PER_TICK is the number of
// system clocks in one 50 us tick; the default assumes a 50 MHz clock.
module lens_dac_sequencer #(
    parameter int CODE_W        = 10,
    parameter int TIME_W        = 5,
    parameter int RES_W         = 3,
    parameter int CLKS_PER_TICK = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_en,
    input  logic              mode_sel,
    input  logic [CODE_W-1:0] ref_code,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] dac_code,
    output logic [1:0]        seq_phase,
    output logic              seq_done
);
    logic [CODE_W-1:0] pt_a;
    logic [CODE_W-1:0] pt_b;
    logic [CODE_W-1:0] pt_c;
    logic [TIME_W-1:0] step_ticks;
    logic [RES_W-1:0]  step_incr;
    logic              seq_busy;
    logic              timer_load;
    logic              step_expire;

    lds_regs #(
        .CODE_W(CODE_W),
        .TIME_W(TIME_W),
        .RES_W (RES_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .lock      (seq_busy),
        .pt_a      (pt_a),
        .pt_b      (pt_b),
        .pt_c      (pt_c),
        .step_ticks(step_ticks),
        .step_incr (step_incr)
    );

    lds_step_timer #(
        .TIME_W       (TIME_W),
        .CLKS_PER_TICK(CLKS_PER_TICK)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .ticks (step_ticks),
        .expire(step_expire)
    );

    lds_seq_fsm #(
        .CODE_W(CODE_W),
        .RES_W (RES_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_en     (seq_en),
        .mode_sel   (mode_sel),
        .ref_code   (ref_code),
        .pt_a       (pt_a),
        .pt_b       (pt_b),
        .pt_c       (pt_c),
        .step_incr  (step_incr),
        .step_expire(step_expire),
        .dac_code   (dac_code),
        .seq_phase  (seq_phase),
        .seq_done   (seq_done),
        .busy       (seq_busy),
        .timer_load (timer_load)
    );

endmodule

// File: rtl/lds_checker.sv
// Protocol checker for lens_dac_sequencer, attached with bind below.
// Observes the ports plus the point registers and the lock signal.
module lds_checker #(
    parameter int CODE_W = 10,
    parameter int RES_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seq_en,
    input logic              mode_sel,
    input logic [CODE_W-1:0] dac_code,
    input logic [1:0]        seq_phase,
    input logic              seq_done,
    input logic [CODE_W-1:0] pt_a,
    input logic [CODE_W-1:0] pt_b,
    input logic [CODE_W-1:0] pt_c,
    input logic              busy
);
    import lds_pkg::*;

    localparam logic [CODE_W-1:0] MAX_INC = CODE_W'((1 << RES_W) - 1);

    AST_IDLE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == PH_IDLE && !mode_sel) |=> (seq_phase == PH_IDLE)); // R3

    AST_STEP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == PH_STEP && $past(seq_phase) == PH_STEP) |->
        (dac_code >= $past(dac_code) && (dac_code - $past(dac_code)) <= MAX_INC)); // R5

    AST_STEP_BELOW_B: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == PH_STEP) |-> (dac_code < pt_b)); // R6

    AST_DONE_IN_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (seq_phase == PH_FINAL)); // R8

    AST_DONE_AT_C: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> (dac_code == pt_c)); // R8

    AST_POINTS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> (pt_a == $past(pt_a) && pt_b == $past(pt_b) && pt_c == $past(pt_c))); // R11

    AST_EN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(seq_en) |->
        (seq_phase == PH_IDLE && !seq_done && dac_code == $past(dac_code))); // R12

endmodule

bind lens_dac_sequencer lds_checker #(
    .CODE_W(CODE_W),
    .RES_W (RES_W)
) u_lds_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .seq_en   (seq_en),
    .mode_sel (mode_sel),
    .dac_code (dac_code),
    .seq_phase(seq_phase),
    .seq_done (seq_done),
    .pt_a     (pt_a),
    .pt_b     (pt_b),
    .pt_c     (pt_c),
    .busy     (seq_busy)
);

// File: tb/test_lens_dac_sequencer.sv
// Self-checking bench: a vector table of full sequences, then directed
// tests for reset, start conditions, select decode, locking and abort.
module test_lens_dac_sequencer;

    localparam int TICK = 4;
    localparam int NV   = 7;
    localparam int VA  [NV] = '{100,   0, 200, 500,  10, 1020,  10};
    localparam int VB  [NV] = '{110,  50, 201, 400,  20, 1023,  24};
    localparam int VC  [NV] = '{300,  60, 202, 600, 700, 1000,  30};
    localparam int VCTL[NV] = '{ 98,  33,   0,  33,  33,  225, 255};
    localparam int VREF[NV] = '{  0,   0,   0,   0,   5,    0,   0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seq_en = 1'b0;
    logic       mode_sel = 1'b0;
    logic [9:0] ref_code = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [9:0] wr_data = '0;
    logic [9:0] dac_code;
    logic [1:0] seq_phase;
    logic       seq_done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    lens_dac_sequencer #(.CLKS_PER_TICK(TICK)) i_lens_dac_sequencer (
        .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .mode_sel(mode_sel),
        .ref_code(ref_code), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .dac_code(dac_code), .seq_phase(seq_phase), .seq_done(seq_done)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input int data);
        wr_en = 1'b1; wr_sel = sel; wr_data = 10'(data);
        tick(1);
        wr_en = 1'b0;
    endtask

    // Program, start and follow one sequence, predicting every change.
    task automatic run_vec(input int a, input int b, input int c, input int ctl, input int rf);
        int prev, cur, nt, inc;
        seq_en = 1'b0; tick(1);
        mode_sel = 1'b1; ref_code = 10'(rf);
        wr(3'b001, a); wr(3'b010, b); wr(3'b011, c); wr(3'b111, ctl);
        nt  = ((ctl & 31) == 0) ? 1 : (ctl & 31);
        inc = (((ctl >> 5) & 7) == 0) ? 1 : ((ctl >> 5) & 7);
        prev = int'(dac_code);
        seq_en = 1'b1; tick(1);
        if (rf != 0) begin
            check("R9", "phase at start", int'(seq_phase), 3);
            check("R9", "code held at start", int'(dac_code), prev);
        end else begin
            cur = (a != 0) ? a : b;
            check("R4", "direct phase", int'(seq_phase), 1);
            check("R4", "direct code", int'(dac_code), cur);
            tick(1);
            if (cur >= b) begin
                check("R7", "skip to final", int'(seq_phase), 3);
            end else begin
                check("R5", "step phase", int'(seq_phase), 2);
                while (cur < b) begin
                    tick(nt * TICK - 1);
                    check("R5", "code stable within step (R10 period)", int'(dac_code), cur);
                    tick(1);
                    cur = (cur + inc > b) ? b : cur + inc;
                    check("R6", "stepped code (R10 incr)", int'(dac_code), cur);
                end
                check("R6", "final after reaching B", int'(seq_phase), 3);
            end
        end
        tick(1);
        check("R8", "code at target", int'(dac_code), c);
        check("R8", "done set", int'(seq_done), 1);
        tick(3);
        check("R8", "target held", int'(dac_code), c);
        seq_en = 1'b0; tick(1);
        check("R12", "idle after EN low", int'(seq_phase), 0);
        check("R12", "done cleared", int'(seq_done), 0);
        check("R12", "code held", int'(dac_code), c);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        check("R1", "reset code", int'(dac_code), 0);
        check("R1", "reset phase", int'(seq_phase), 0);
        check("R1", "reset done", int'(seq_done), 0);

        // R1: start point defaults to 0, so the first move lands on B.
        mode_sel = 1'b1;
        wr(3'b010, 80); wr(3'b011, 90);
        seq_en = 1'b1; tick(1);
        check("R1", "default A jumps to B", int'(dac_code), 80);
        seq_en = 1'b0; tick(1);

        // Table of full sequences.
        for (int i = 0; i < NV; i++) run_vec(VA[i], VB[i], VC[i], VCTL[i], VREF[i]);

        // R3: mode bit low blocks the start.
        mode_sel = 1'b0; ref_code = '0;
        wr(3'b010, 40); wr(3'b011, 45);
        seq_en = 1'b1; tick(3);
        check("R3", "no start with mode 0", int'(seq_phase), 0);
        seq_en = 1'b0; tick(1);
        // R3: zero float point blocks the start.
        mode_sel = 1'b1; wr(3'b010, 0);
        seq_en = 1'b1; tick(3);
        check("R3", "no start with B=0", int'(seq_phase), 0);
        seq_en = 1'b0; tick(1);

        // R2: unused selects leave the points untouched.
        wr(3'b001, 30); wr(3'b010, 40); wr(3'b011, 45); wr(3'b111, 33);
        wr(3'b100, 500); wr(3'b000, 7); wr(3'b110, 900);
        seq_en = 1'b1; tick(1);
        check("R2", "A unchanged by unused select", int'(dac_code), 30);
        tick(200);
        check("R2", "C unchanged by unused select", int'(dac_code), 45);
        seq_en = 1'b0; tick(1);

        // R11: point writes during a run are ignored, accepted after done.
        wr(3'b001, 10); wr(3'b010, 20); wr(3'b011, 25); wr(3'b111, 33);
        seq_en = 1'b1; tick(1);
        wr(3'b010, 12); wr(3'b011, 999); wr(3'b001, 0);
        tick(200);
        check("R11", "locked C used", int'(dac_code), 25);
        check("R11", "done after locked run", int'(seq_done), 1);
        wr(3'b011, 77);
        seq_en = 1'b0; tick(1);
        seq_en = 1'b1; tick(1);
        check("R11", "locked A write ignored", int'(dac_code), 10);
        tick(200);
        check("R11", "C written after done", int'(dac_code), 77);
        seq_en = 1'b0; tick(1);

        // R12: clearing EN mid-staircase holds the code.
        wr(3'b001, 100); wr(3'b010, 200); wr(3'b011, 300); wr(3'b111, 37);
        seq_en = 1'b1; tick(1);
        tick(1);
        tick(60);
        check("R5", "three steps of one code", int'(dac_code), 103);
        seq_en = 1'b0; tick(1);
        check("R12", "abort to idle", int'(seq_phase), 0);
        check("R12", "abort holds code", int'(dac_code), 103);
        tick(50);
        check("R12", "code stays held", int'(dac_code), 103);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule